// File: doc/BRIEF.md
# Fetch/Execute Overlap Sequencer

This block sits between a single-ported synchronous memory and an execute stage. It splits instruction handling into two segments. The fetch segment reads instruction words and keeps one of them ready for execute. The execute segment takes that word when it is free. The execute segment may also issue its own data reads and writes through the same memory port.

The block arbitrates the shared port and always serves a data access first. It fetches the next word only in cycles that execute leaves idle, and only when the fetched word has somewhere to go. A fetched word reaches execute in the cycle its memory response arrives. If execute cannot take it, the word waits in a one-entry holding register.

The memory returns read data exactly one cycle after a read request, and it performs a write in the cycle it is requested. A redirect input drops everything fetched but not yet consumed, and fetching restarts at the new word address. Addresses are word addresses.

Top module: `prefetch_unit`

## Requirements
- R1: While reset is asserted `ins_valid` is low; after reset is released the first memory request is a read of the word at parameter `RESET_VEC`.
- R2: In any cycle with `dat_req` high, the memory port carries the execute access (`mem_req`=1, `mem_addr`=`dat_addr`, `mem_we`=`dat_we`, `mem_wdata`=`dat_wdata`) whatever the fetch side wants.
- R3: A data read (`dat_req`=1, `dat_we`=0) produces `dat_rvalid`=1 with `dat_rdata` equal to the memory word in the following cycle; a data write produces no `dat_rvalid`.
- R4: A fetch request is issued only in a cycle without `dat_req` and without redirect, and only if no word is held and none is in flight, or the single held/in-flight word is consumed in that same cycle; while execute stalls with a word pending, the port stays idle.
- R5: While `ins_valid` is high and `ins_ready` is low, `ins_word` and `ins_addr` stay unchanged until consumed or redirected; no fetched word is lost or duplicated.
- R6: A fetched word is offered on `ins_valid`/`ins_word` in the cycle after its fetch request. With `ins_ready` held high and no data traffic, one instruction is consumed every cycle.
- R7: Words are offered in order of increasing address, each one word after the previous, starting at the reset vector or the last redirect target; `ins_word` is the memory content at `ins_addr`.
- R8: In the cycle `redir_valid` is high, `ins_valid` is low and no fetch is issued. The held word and any word in flight are discarded. The next cycle fetches `redir_addr`, and the first word offered afterwards comes from `redir_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | 1 | Memory access request this cycle |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after a read |
| ins_valid | output | 1 | Instruction word offered to execute |
| ins_ready | input | 1 | Execute is free to take the word |
| ins_word | output | DW | Offered instruction word |
| ins_addr | output | AW | Address of the offered word |
| dat_req | input | 1 | Execute data access request |
| dat_we | input | 1 | Execute access is a write |
| dat_addr | input | AW | Execute data address |
| dat_wdata | input | DW | Execute write data |
| dat_rvalid | output | 1 | Data read reply valid |
| dat_rdata | output | DW | Data read reply |
| redir_valid | input | 1 | Redirect fetching |
| redir_addr | input | AW | Redirect target word address |

## Verification
On every cycle, the assertions check the following:
- a data read is answered in the next cycle;
- the holding register never receives a word while occupied and stalled;
- a pending word stays stable;
- the fetch pointer steps by one per granted fetch;
- a redirect loads the pointer;
- every granted fetch yields an offered word one cycle later.

Only the bench scenarios can show the rest, because these properties cover whole sequences of words:
- the exact order and content of the words consumed across stalls, data bursts and redirects;
- one-per-cycle throughput;
- the port falling silent during a stall;
- discarded words never reaching execute after a redirect.

// File: rtl/pf_pkg.sv
package pf_pkg;

  // Kind of access whose reply arrives in the current cycle
  typedef enum logic [1:0] {
    RSP_NONE  = 2'd0,
    RSP_FETCH = 2'd1,
    RSP_DREAD = 2'd2
  } pf_rsp_e;

  // At most one word may be held or in flight; a new fetch is allowed
  // when none is, or when the single one is taken this cycle.
  function automatic logic pf_may_fetch(input logic held, input logic flying,
                                        input logic taken);
    return (!held && !flying) || ((held ^ flying) && taken);
  endfunction

endpackage

// File: rtl/pf_arbiter.sv
module pf_arbiter
  import pf_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dat_req,
  input  logic          dat_we,
  input  logic [AW-1:0] dat_addr,
  input  logic [DW-1:0] dat_wdata,
  input  logic          fetch_want,
  input  logic [AW-1:0] fetch_addr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          fetch_grant,
  output pf_rsp_e       rsp_kind
);

  pf_rsp_e rsp_kind_d;

  always_comb begin
    fetch_grant = fetch_want && !dat_req;
    mem_req     = dat_req || fetch_want;
    mem_we      = dat_req && dat_we;
    mem_addr    = dat_req ? dat_addr : fetch_addr;
    mem_wdata   = dat_wdata;
    if (dat_req)          rsp_kind_d = dat_we ? RSP_NONE : RSP_DREAD;
    else if (fetch_grant) rsp_kind_d = RSP_FETCH;
    else                  rsp_kind_d = RSP_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_kind <= RSP_NONE;
    else        rsp_kind <= rsp_kind_d;
  end

  assert_read_reply_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_req && !dat_we) |=> (rsp_kind == RSP_DREAD));

  assert_write_no_reply_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_req && dat_we) |=> (rsp_kind == RSP_NONE));

endmodule

// File: rtl/pf_fetch_ctrl.sv
module pf_fetch_ctrl
  import pf_pkg::*;
#(
  parameter int          AW        = 16,
  parameter logic [AW-1:0] RESET_VEC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          redir_valid,
  input  logic [AW-1:0] redir_addr,
  input  logic          buf_held,
  input  logic          rsp_fetch,
  input  logic          taken,
  input  logic          fetch_grant,
  output logic          fetch_want,
  output logic [AW-1:0] fetch_addr,
  output logic [AW-1:0] rsp_addr
);

  localparam logic [AW-1:0] WORD_STEP = AW'(1);

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a);
    return a + WORD_STEP;
  endfunction

  logic [AW-1:0] pc_q;
  logic [AW-1:0] flying_addr_q;

  assign fetch_addr = pc_q;
  assign rsp_addr   = flying_addr_q;
  assign fetch_want = !redir_valid && pf_may_fetch(buf_held, rsp_fetch, taken);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q          <= RESET_VEC;
      flying_addr_q <= RESET_VEC;
    end else if (redir_valid) begin
      pc_q <= redir_addr;
    end else if (fetch_grant) begin
      pc_q          <= step_addr(pc_q);
      flying_addr_q <= pc_q;
    end
  end

  assert_seq_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_grant |=> (fetch_addr == step_addr($past(fetch_addr))));

  assert_redirect_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> (fetch_addr == $past(redir_addr)));

endmodule

// File: rtl/pf_hold_buf.sv
module pf_hold_buf #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          rsp_fetch,
  input  logic [DW-1:0] rsp_word,
  input  logic [AW-1:0] rsp_addr,
  input  logic          ins_ready,
  output logic          ins_valid,
  output logic [DW-1:0] ins_word,
  output logic [AW-1:0] ins_addr,
  output logic          buf_held,
  output logic          taken
);

  logic          held_q;
  logic [DW-1:0] word_q;
  logic [AW-1:0] addr_q;
  logic          load_rsp;

  always_comb begin
    ins_valid = !flush && (held_q || rsp_fetch);
    ins_word  = held_q ? word_q : rsp_word;
    ins_addr  = held_q ? addr_q : rsp_addr;
    taken     = ins_valid && ins_ready;
    buf_held  = held_q;
    // a reply is parked unless it passes straight through to execute
    load_rsp  = rsp_fetch && !(taken && !held_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      word_q <= '0;
      addr_q <= '0;
    end else if (flush) begin
      held_q <= 1'b0;
    end else if (load_rsp) begin
      held_q <= 1'b1;
      word_q <= rsp_word;
      addr_q <= rsp_addr;
    end else if (taken) begin
      held_q <= 1'b0;
    end
  end

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_fetch && held_q && !ins_ready && !flush));

  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !ins_ready) |=>
      (flush || (ins_valid && $stable(ins_word) && $stable(ins_addr))));

endmodule

// File: rtl/prefetch_unit.sv
module prefetch_unit
  import pf_pkg::*;
#(
  parameter int            AW        = 16,
  parameter int            DW        = 32,
  parameter logic [AW-1:0] RESET_VEC = 16'h0100
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          ins_valid,
  input  logic          ins_ready,
  output logic [DW-1:0] ins_word,
  output logic [AW-1:0] ins_addr,
  input  logic          dat_req,
  input  logic          dat_we,
  input  logic [AW-1:0] dat_addr,
  input  logic [DW-1:0] dat_wdata,
  output logic          dat_rvalid,
  output logic [DW-1:0] dat_rdata,
  input  logic          redir_valid,
  input  logic [AW-1:0] redir_addr
);

  // named internal events
  logic          fetch_want;
  logic          fetch_grant;
  logic [AW-1:0] fetch_addr;
  logic [AW-1:0] rsp_addr;
  logic          buf_held;
  logic          taken;
  logic          rsp_fetch;
  pf_rsp_e       rsp_kind;

  assign rsp_fetch  = (rsp_kind == RSP_FETCH);
  assign dat_rvalid = (rsp_kind == RSP_DREAD);
  assign dat_rdata  = mem_rdata;

  pf_arbiter #(.AW(AW), .DW(DW)) arb_i (
    .clk(clk), .rst_n(rst_n),
    .dat_req(dat_req), .dat_we(dat_we), .dat_addr(dat_addr), .dat_wdata(dat_wdata),
    .fetch_want(fetch_want), .fetch_addr(fetch_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .fetch_grant(fetch_grant), .rsp_kind(rsp_kind)
  );

  pf_fetch_ctrl #(.AW(AW), .RESET_VEC(RESET_VEC)) fet_i (
    .clk(clk), .rst_n(rst_n),
    .redir_valid(redir_valid), .redir_addr(redir_addr),
    .buf_held(buf_held), .rsp_fetch(rsp_fetch), .taken(taken),
    .fetch_grant(fetch_grant), .fetch_want(fetch_want),
    .fetch_addr(fetch_addr), .rsp_addr(rsp_addr)
  );

  pf_hold_buf #(.AW(AW), .DW(DW)) buf_i (
    .clk(clk), .rst_n(rst_n),
    .flush(redir_valid), .rsp_fetch(rsp_fetch),
    .rsp_word(mem_rdata), .rsp_addr(rsp_addr),
    .ins_ready(ins_ready), .ins_valid(ins_valid),
    .ins_word(ins_word), .ins_addr(ins_addr),
    .buf_held(buf_held), .taken(taken)
  );

  assert_one_cycle_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_grant |=> (ins_valid || redir_valid));

  assert_exec_port_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dat_req |-> !fetch_grant);

  assert_redirect_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> !rsp_fetch);

endmodule

// File: tb/prefetch_unit_tb.sv
module prefetch_unit_tb_top;

  localparam int            AW  = 16;
  localparam int            DW  = 32;
  localparam logic [AW-1:0] RST_VEC = 16'h0100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic          ins_valid;
  logic          ins_ready = 1'b1;
  logic [DW-1:0] ins_word;
  logic [AW-1:0] ins_addr;
  logic          dat_req = 1'b0, dat_we = 1'b0;
  logic [AW-1:0] dat_addr = '0;
  logic [DW-1:0] dat_wdata = '0;
  logic          dat_rvalid;
  logic [DW-1:0] dat_rdata;
  logic          redir_valid = 1'b0;
  logic [AW-1:0] redir_addr = '0;

  int n_run = 0;
  int n_fail = 0;
  int n_taken = 0;
  bit done = 1'b0;

  logic [AW-1:0] iq[$];
  logic [DW-1:0] dq[$];
  logic [DW-1:0] mem [256];

  always #4 clk = ~clk;

  prefetch_unit #(.AW(AW), .DW(DW), .RESET_VEC(RST_VEC)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_word(ins_word), .ins_addr(ins_addr),
    .dat_req(dat_req), .dat_we(dat_we), .dat_addr(dat_addr),
    .dat_wdata(dat_wdata), .dat_rvalid(dat_rvalid), .dat_rdata(dat_rdata),
    .redir_valid(redir_valid), .redir_addr(redir_addr)
  );

  function automatic logic [DW-1:0] init_word(input logic [AW-1:0] a);
    return (DW'(a[7:0]) * 32'h0100_0193) ^ 32'h5EED_0000;
  endfunction

  // memory model: read reply one cycle later, write in the request cycle
  initial for (int i = 0; i < 256; i++) mem[i] = init_word(AW'(i));
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[7:0]];
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic push_run(input logic [AW-1:0] start, input int n);
    iq.delete();
    for (int k = 0; k < n; k++) iq.push_back(start + AW'(k));
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (dat_req)
        check(mem_req && mem_addr == dat_addr && mem_we == dat_we
              && mem_wdata == dat_wdata, "R2 exec access owns port",
              32'(mem_addr), 32'(dat_addr));
      if (ins_valid && ins_ready) begin
        n_taken++;
        if (iq.size() == 0) begin
          check(1'b0, "R7 unexpected instruction", 32'(ins_addr), 32'hFFFF_FFFF);
        end else begin
          automatic logic [AW-1:0] ea = iq.pop_front();
          check(ins_addr == ea, "R7 instruction order", 32'(ins_addr), 32'(ea));
          check(ins_word == init_word(ea), "R7 instruction word",
                ins_word, init_word(ea));
        end
      end
      if (dat_rvalid) begin
        if (dq.size() == 0) begin
          check(1'b0, "R3 reply without read", dat_rdata, 32'h0);
        end else begin
          automatic logic [DW-1:0] ed = dq.pop_front();
          check(dat_rdata == ed, "R3 read data", dat_rdata, ed);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 32'h0, 32'h1);
    report();
  end

  initial begin
    logic [DW-1:0] hold_w;
    logic [AW-1:0] hold_a;
    int base;

    // R1: reset
    repeat (3) begin
      @(negedge clk);
      check(ins_valid == 1'b0, "R1 no instruction in reset", 32'(ins_valid), 32'h0);
    end
    tick();
    push_run(RST_VEC, 256);
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_req && !mem_we && mem_addr == RST_VEC, "R1 first fetch at reset vector",
          32'(mem_addr), 32'(RST_VEC));

    // R6: throughput one per cycle
    repeat (3) tick();
    base = n_taken;
    repeat (16) tick();
    @(negedge clk);
    check(n_taken - base == 16, "R6 one instruction per cycle",
          32'(n_taken - base), 32'd16);

    // R4/R5: stall with a word pending
    tick();
    ins_ready = 1'b0;
    @(negedge clk);
    hold_w = ins_word;
    hold_a = ins_addr;
    check(ins_valid, "R5 word offered at stall", 32'(ins_valid), 32'h1);
    for (int k = 0; k < 6; k++) begin
      tick();
      @(negedge clk);
      check(ins_valid && ins_word == hold_w && ins_addr == hold_a,
            "R5 pending word stable", ins_word, hold_w);
      check(!mem_req, "R4 port idle while stalled", 32'(mem_req), 32'h0);
    end
    tick();
    ins_ready = 1'b1;
    repeat (4) tick();

    // R2/R3/R4: data burst of four accesses
    dat_req = 1'b1; dat_we = 1'b1; dat_addr = 16'h02F0; dat_wdata = 32'hA5A5_0F0F;
    tick();
    dat_we = 1'b0; dat_addr = 16'h02F0; dq.push_back(32'hA5A5_0F0F);
    tick();
    dat_addr = 16'h02E0; dq.push_back(init_word(16'h02E0));
    @(negedge clk);
    check(!ins_valid, "R4 fetch yields port to data burst", 32'(ins_valid), 32'h0);
    tick();
    dat_we = 1'b1; dat_addr = 16'h02E8; dat_wdata = 32'h1234_5678;
    tick();
    dat_req = 1'b0; dat_we = 1'b0;
    @(negedge clk);
    check(!dat_rvalid, "R3 write gives no reply", 32'(dat_rvalid), 32'h0);
    repeat (5) tick();

    // R8: redirect while running
    redir_valid = 1'b1; redir_addr = 16'h0140;
    push_run(16'h0140, 256);
    @(negedge clk);
    check(!ins_valid, "R8 no instruction in redirect cycle", 32'(ins_valid), 32'h0);
    check(!mem_req, "R8 no fetch in redirect cycle", 32'(mem_req), 32'h0);
    tick();
    redir_valid = 1'b0;
    @(negedge clk);
    check(mem_req && !mem_we && mem_addr == 16'h0140, "R8 fetch at target",
          32'(mem_addr), 32'h0140);
    tick();
    @(negedge clk);
    check(ins_valid && ins_addr == 16'h0140, "R6 word offered one cycle after fetch",
          32'(ins_addr), 32'h0140);
    repeat (6) tick();

    // R8: redirect with a word held and execute stalled
    ins_ready = 1'b0;
    repeat (4) tick();
    redir_valid = 1'b1; redir_addr = 16'h0180;
    push_run(16'h0180, 256);
    tick();
    redir_valid = 1'b0;
    repeat (2) tick();
    ins_ready = 1'b1;
    @(negedge clk);
    check(ins_valid && ins_addr == 16'h0180, "R8 held word discarded",
          32'(ins_addr), 32'h0180);
    repeat (10) tick();

    @(negedge clk);
    check(dq.size() == 0, "R3 all reads answered", 32'(dq.size()), 32'h0);
    done = 1'b1;
    report();
  end

endmodule